// File: doc/BRIEF.md
# Two-Level SMI Cause Aggregator

This block gathers system-management interrupt causes into one 16-bit top-level status word and drives a single SMI request line toward the processor. Four causes are recorded directly in the top word: a super-I/O interrupt line, NMI activity, a warm-reset command and USB activity. Each of these is a sticky flag that clears when software reads the clearing address. Five more causes each report through a small second-level status group held inside the block: power management, audio, ACPI register access, LPC and video retrace. Their top-level bits are read-only. Each one is the OR of its group, so it drops only when software has written-one-to-clear every bit of that group.

Software uses a synchronous register port with one-cycle read and write strobes, and read data is combinational on the address. Address 1 returns the status word and clears the sticky flags. Address 0 returns the same word and changes nothing, so a handler can inspect the causes without dropping the request. Addresses 2 to 6 are the second-level groups for top bits 0, 1, 2, 3 and 5, in that order. Writing 1 to a bit position in one of these addresses clears that bit.

Top module: `smi_status_agg`

## Requirements
- R1: After a synchronous reset every status flag and every second-level bit is 0 and `smi_req` is low. A read at address 0 then returns only bit 15, which equals `susp_mod_cfg`.
- R2: A one-cycle pulse on `evt_sio_irq2`, `evt_nmi`, `evt_warm_rst` or `evt_usb` sets status bit 11, 12, 13 or 14 respectively at the next clock edge, and the bit stays set until a clearing read.
- R3: A read at address 1 returns the current status word and clears bits 11 to 14 at that clock edge. It leaves bits 0 to 3 and bit 5 unchanged.
- R4: A read at address 0 returns the same word as address 1 and clears nothing.
- R5: Status bits 0, 1, 2, 3 and 5 equal the OR of second-level groups 0 to 4, which are at addresses 2 to 6. Each of these bits falls only after every bit of its group has been cleared.
- R6: Each second-level bit is set by a one-cycle pulse on its position of `l2_evt`, where group g occupies bits [g*SUB_W +: SUB_W]. A write to the group's address clears exactly the positions where `bus_wdata` is 1. A pulse in the same cycle as a write keeps its bit set. Reading a group address returns the group in the low bits, and unmapped address 7 reads 0.
- R7: Status bit 4 always reads 0. Status bit 15 always reads the present value of `susp_mod_cfg` and is not an event.
- R8: A USB pulse is recorded only while `usb_en` is 2'b11. Video-retrace pulses (group 4) are recorded only while `vrt_en` is 1.
- R9: `smi_req` is a register. At each clock edge it takes the OR of status bits 0 to 3, 5 and 11 to 14 as they were before that edge, so it rises one cycle after the first such bit sets and falls one cycle after the last one clears.
- R10: When a sticky event arrives in the same cycle as a clearing read, the read returns the value without that event, and the event is held in the status word afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_sio_irq2 | input | 1 | Super-I/O interrupt cause pulse |
| evt_nmi | input | 1 | NMI cause pulse |
| evt_warm_rst | input | 1 | Warm-reset command cause pulse |
| evt_usb | input | 1 | USB cause pulse |
| usb_en | input | 2 | USB cause enable, both bits must be 1 |
| vrt_en | input | 1 | Video-retrace cause enable |
| l2_evt | input | N_GRP*SUB_W | Second-level cause pulses, group g at [g*SUB_W +: SUB_W] |
| susp_mod_cfg | input | 1 | Suspend-modulation configuration, shown in bit 15 |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| smi_req | output | 1 | Active-high SMI request |

## Verification
The hardest case to reach is a read-only top bit that holds while its group is partly cleared, combined with sticky clears and new events arriving on the same edge. A directed sequence sets two bits of one group, clears them one write at a time and watches the top bit and `smi_req` through the mirror address. A second directed step pulses NMI on the same cycle as a clearing read. Seeded random cycles then mix sparse pulses, enable settings, reads and clear-writes at all eight addresses, and every read and every cycle of `smi_req` is compared with a bench model.

// File: rtl/smi_agg_pkg.sv
`timescale 1ns/1ps
package smi_agg_pkg;
    localparam int STAT_W   = 16;
    localparam int N_GRP    = 5;
    localparam int N_STICKY = 4;

    localparam int BIT_RSV  = 4;
    localparam int BIT_VRT  = 5;
    localparam int BIT_STK0 = 11;
    localparam int BIT_SUSP = 15;

    localparam int ADDR_MIR  = 0;
    localparam int ADDR_CLR  = 1;
    localparam int ADDR_GRP0 = 2;

    typedef logic [STAT_W-1:0] stat_t;

    localparam stat_t STICKY_MASK = 16'h7800;
    localparam stat_t RO_MASK     = 16'h002F;
    localparam stat_t SMI_MASK    = STICKY_MASK | RO_MASK;

    typedef struct packed {
        logic usb;
        logic wrst;
        logic nmi;
        logic sio;
    } sticky_t;

    function automatic int grp_bit(input int g);
        return (g == N_GRP - 1) ? BIT_VRT : g;
    endfunction
endpackage

// File: rtl/smi_sticky_bank.sv
`timescale 1ns/1ps
module smi_sticky_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= (clr_i ? '0 : q_r) | set_i;
    end

    assign q_o = q_r;
endmodule

// File: rtl/smi_l2_group.sv
`timescale 1ns/1ps
module smi_l2_group #(
    parameter int SUB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SUB_W-1:0] evt_i,
    input  logic             w1c_i,
    input  logic [SUB_W-1:0] wdata_i,
    output logic [SUB_W-1:0] q_o,
    output logic             any_o
);
    logic [SUB_W-1:0] q_r;
    logic [SUB_W-1:0] clr_bits;

    assign clr_bits = w1c_i ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= (q_r & ~clr_bits) | evt_i;
    end

    assign q_o   = q_r;
    assign any_o = |q_r;
endmodule

// File: rtl/smi_req_gen.sv
`timescale 1ns/1ps
module smi_req_gen
    import smi_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t stat_i,
    output logic  req_o
);
    logic req_r;

    always_ff @(posedge clk) begin
        if (rst) req_r <= 1'b0;
        else     req_r <= |(stat_i & SMI_MASK);
    end

    assign req_o = req_r;
endmodule

// File: rtl/smi_status_agg.sv
`timescale 1ns/1ps
module smi_status_agg
    import smi_agg_pkg::*;
#(
    parameter int SUB_W  = 4,
    parameter int ADDR_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   evt_sio_irq2,
    input  logic                   evt_nmi,
    input  logic                   evt_warm_rst,
    input  logic                   evt_usb,
    input  logic [1:0]             usb_en,
    input  logic                   vrt_en,
    input  logic [N_GRP*SUB_W-1:0] l2_evt,
    input  logic                   susp_mod_cfg,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [STAT_W-1:0]      bus_wdata,
    output logic [STAT_W-1:0]      bus_rdata,
    output logic                   smi_req
);
    localparam logic [ADDR_W-1:0] A_MIR = ADDR_W'(ADDR_MIR);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_CLR);

    sticky_t          sticky_set;
    logic [N_STICKY-1:0] sticky_q;
    logic             clr_rd;
    logic [SUB_W-1:0] grp_q [N_GRP];
    logic [N_GRP-1:0] grp_any;
    stat_t            stat_word;

    // sticky causes, USB gated by its two-bit enable
    assign sticky_set.usb  = evt_usb & (&usb_en);
    assign sticky_set.wrst = evt_warm_rst;
    assign sticky_set.nmi  = evt_nmi;
    assign sticky_set.sio  = evt_sio_irq2;
    assign clr_rd          = bus_rd && (bus_addr == A_CLR);

    smi_sticky_bank #(.W(N_STICKY)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (sticky_set),
        .clr_i (clr_rd),
        .q_o   (sticky_q)
    );

    // second-level groups; the last one is the enable-gated video retrace group
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic [SUB_W-1:0] evt_g;
        logic             w1c_g;

        if (g == N_GRP - 1) begin : g_gated
            assign evt_g = l2_evt[g*SUB_W +: SUB_W] & {SUB_W{vrt_en}};
        end else begin : g_plain
            assign evt_g = l2_evt[g*SUB_W +: SUB_W];
        end

        assign w1c_g = bus_wr && (bus_addr == ADDR_W'(ADDR_GRP0 + g));

        smi_l2_group #(.SUB_W(SUB_W)) u_grp (
            .clk     (clk),
            .rst     (rst),
            .evt_i   (evt_g),
            .w1c_i   (w1c_g),
            .wdata_i (bus_wdata[SUB_W-1:0]),
            .q_o     (grp_q[g]),
            .any_o   (grp_any[g])
        );
    end

    // top-level word assembly
    always_comb begin
        stat_word = '0;
        for (int g = 0; g < N_GRP; g++) begin
            stat_word[grp_bit(g)] = grp_any[g];
        end
        stat_word[BIT_STK0 +: N_STICKY] = sticky_q;
        stat_word[BIT_RSV]              = 1'b0;
        stat_word[BIT_SUSP]             = susp_mod_cfg;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MIR || bus_addr == A_CLR) begin
            bus_rdata = stat_word;
        end
        for (int g = 0; g < N_GRP; g++) begin
            if (bus_addr == ADDR_W'(ADDR_GRP0 + g)) begin
                bus_rdata[SUB_W-1:0] = grp_q[g];
            end
        end
    end

    smi_req_gen u_req (
        .clk    (clk),
        .rst    (rst),
        .stat_i (stat_word),
        .req_o  (smi_req)
    );
endmodule

// File: rtl/smi_status_agg_chk.sv
`timescale 1ns/1ps
module smi_status_agg_chk
    import smi_agg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [STAT_W-1:0] bus_rdata,
    input logic              susp_cfg,
    input logic              smi_req,
    input stat_t             stat
);
    localparam logic [ADDR_W-1:0] A_MIR = ADDR_W'(ADDR_MIR);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_CLR);

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == A_CLR) |=>
        ((stat & $past(stat) & STICKY_MASK) == ($past(stat) & STICKY_MASK))); // R2

    AST_MIRROR_NO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_MIR) |=>
        ((stat & $past(stat) & STICKY_MASK) == ($past(stat) & STICKY_MASK))); // R4

    AST_RO_KEEP: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ((stat & $past(stat) & RO_MASK) == ($past(stat) & RO_MASK))); // R5

    AST_READ_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_MIR || bus_addr == A_CLR)) |->
        (bus_rdata[BIT_RSV] == 1'b0 && bus_rdata[BIT_SUSP] == susp_cfg)); // R7

    AST_SMI_RISE: assert property (@(posedge clk) disable iff (rst)
        (|(stat & SMI_MASK)) |=> smi_req); // R9

    AST_SMI_FALL: assert property (@(posedge clk) disable iff (rst)
        !(|(stat & SMI_MASK)) |=> !smi_req); // R9
endmodule

bind smi_status_agg smi_status_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .susp_cfg  (susp_mod_cfg),
    .smi_req   (smi_req),
    .stat      (stat_word)
);

// File: tb/smi_status_agg_bench.sv
`timescale 1ns/1ps
module smi_status_agg_bench;
    import smi_agg_pkg::*;

    localparam int SUB_W  = 4;
    localparam int ADDR_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic evt_sio_irq2 = 0, evt_nmi = 0, evt_warm_rst = 0, evt_usb = 0;
    logic [1:0] usb_en = '0;
    logic vrt_en = 0;
    logic [N_GRP*SUB_W-1:0] l2_evt = '0;
    logic susp_mod_cfg = 0;
    logic bus_rd = 0, bus_wr = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [STAT_W-1:0] bus_wdata = '0;
    logic [STAT_W-1:0] bus_rdata;
    logic smi_req;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [3:0]       m_sticky = '0;
    logic [SUB_W-1:0] m_grp [N_GRP];
    logic             m_smi = 1'b0;

    always #5 clk = ~clk;

    smi_status_agg #(.SUB_W(SUB_W), .ADDR_W(ADDR_W)) u_smi_status_agg (
        .clk(clk), .rst(rst),
        .evt_sio_irq2(evt_sio_irq2), .evt_nmi(evt_nmi),
        .evt_warm_rst(evt_warm_rst), .evt_usb(evt_usb),
        .usb_en(usb_en), .vrt_en(vrt_en), .l2_evt(l2_evt),
        .susp_mod_cfg(susp_mod_cfg),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smi_req(smi_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic stat_t m_stat();
        stat_t s = '0;
        for (int g = 0; g < N_GRP; g++) s[(g == N_GRP-1) ? 5 : g] = |m_grp[g];
        s[14:11] = m_sticky;
        s[15]    = susp_mod_cfg;
        return s;
    endfunction

    function automatic stat_t m_read(input logic [ADDR_W-1:0] a);
        if (a == 0 || a == 1) return m_stat();
        if (a >= 2 && a <= 6) return stat_t'(m_grp[a-2]);
        return '0;
    endfunction

    function automatic string tag_of(input logic [ADDR_W-1:0] a);
        if (a == 1) return "R3";
        if (a == 0) return "R4";
        return "R6";
    endfunction

    task automatic idle();
        evt_sio_irq2 = 0; evt_nmi = 0; evt_warm_rst = 0; evt_usb = 0;
        l2_evt = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    endtask

    // one cycle: check outputs before the edge, advance the model at the edge
    task automatic tick();
        logic [3:0]       nx_sticky;
        logic [SUB_W-1:0] nx_grp [N_GRP];
        logic             nx_smi;
        #1;
        if (bus_rd) chk(tag_of(bus_addr), 32'(bus_rdata), 32'(m_read(bus_addr)));
        chk("R9", 32'(smi_req), 32'(m_smi));
        nx_smi    = |(m_stat() & 16'h782F);
        nx_sticky = ((bus_rd && bus_addr == 1) ? 4'b0 : m_sticky)
                  | {evt_usb & (usb_en == 2'b11), evt_warm_rst, evt_nmi, evt_sio_irq2};
        for (int g = 0; g < N_GRP; g++) begin
            logic [SUB_W-1:0] ev, w;
            ev = l2_evt[g*SUB_W +: SUB_W];
            if (g == N_GRP-1) ev = ev & {SUB_W{vrt_en}};
            w = (bus_wr && bus_addr == ADDR_W'(g + 2)) ? bus_wdata[SUB_W-1:0] : '0;
            nx_grp[g] = (m_grp[g] & ~w) | ev;
        end
        @(posedge clk);
        m_sticky = nx_sticky;
        m_smi    = nx_smi;
        for (int g = 0; g < N_GRP; g++) m_grp[g] = nx_grp[g];
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED);
        for (int g = 0; g < N_GRP; g++) m_grp[g] = '0;
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk); #1;

        // R1: reset state
        susp_mod_cfg = 1;
        bus_rd = 1; bus_addr = 0; #1;
        chk("R1", 32'(bus_rdata), 32'h8000);
        chk("R1", 32'(smi_req), 0);
        for (int a = 2; a <= 6; a++) begin
            bus_addr = ADDR_W'(a); #1;
            chk("R1", 32'(bus_rdata), 0);
        end
        idle(); susp_mod_cfg = 0; tick();

        // R7: bit 15 follows config, bit 4 zero
        bus_rd = 1; bus_addr = 0; susp_mod_cfg = 1; #1;
        chk("R7", 32'(bus_rdata[15]), 1);
        chk("R7", 32'(bus_rdata[4]), 0);
        susp_mod_cfg = 0; idle(); tick();

        // R2 / R8: sticky latching, USB enable gating
        evt_nmi = 1; evt_usb = 1; usb_en = 2'b01; tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R2", 32'(bus_rdata[12]), 1);
        chk("R8", 32'(bus_rdata[14]), 0);
        tick(); idle();
        chk("R9", 32'(smi_req), 1);

        // R10: event on the same cycle as a clearing read
        bus_rd = 1; bus_addr = 1; evt_warm_rst = 1; #1;
        chk("R10", 32'(bus_rdata), 32'h1000);
        tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R10", 32'(bus_rdata), 32'h2000);
        tick(); idle();
        bus_rd = 1; bus_addr = 1; tick(); idle();   // R3 clear

        // R5: group 2 top bit falls only once the whole group is clear
        l2_evt[2*SUB_W +: SUB_W] = 4'b0101; tick(); idle();
        bus_wr = 1; bus_addr = 4; bus_wdata = 16'h0001; tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R5", 32'(bus_rdata[2]), 1);
        tick(); idle();
        bus_wr = 1; bus_addr = 4; bus_wdata = 16'h0004; tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R5", 32'(bus_rdata[2]), 0);
        tick(); idle(); tick();
        chk("R9", 32'(smi_req), 0);

        // R8: video retrace group gated by enable
        vrt_en = 0; l2_evt[4*SUB_W +: SUB_W] = 4'b1000; tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R8", 32'(bus_rdata[5]), 0);
        tick(); idle();
        vrt_en = 1; l2_evt[4*SUB_W +: SUB_W] = 4'b1000; tick(); idle();
        bus_rd = 1; bus_addr = 0; #1;
        chk("R8", 32'(bus_rdata[5]), 1);
        tick(); idle();

        // R6: write-one-to-clear loses to a same-cycle event
        bus_wr = 1; bus_addr = 6; bus_wdata = 16'h0008;
        l2_evt[4*SUB_W +: SUB_W] = 4'b1000; tick(); idle();
        bus_rd = 1; bus_addr = 6; #1;
        chk("R6", 32'(bus_rdata), 32'h0008);
        tick(); idle();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            evt_sio_irq2 = ($urandom % 8) == 0;
            evt_nmi      = ($urandom % 8) == 0;
            evt_warm_rst = ($urandom % 8) == 0;
            evt_usb      = ($urandom % 6) == 0;
            usb_en       = 2'($urandom);
            vrt_en       = 1'($urandom);
            for (int b = 0; b < N_GRP*SUB_W; b++) l2_evt[b] = ($urandom % 12) == 0;
            if (($urandom % 16) == 0) susp_mod_cfg = ~susp_mod_cfg;
            bus_rd    = ($urandom % 3) == 0;
            bus_wr    = !bus_rd && (($urandom % 3) == 0);
            bus_addr  = ADDR_W'($urandom);
            bus_wdata = 16'($urandom);
            tick();
        end
        idle();
        tick();
        finish_run();
    end
endmodule